// File: doc/BRIEF.md
# Banked Register Pointer with Wrapping Auto-Increment

This block is the command-pointer and register-bank access logic of a 40-bit general-purpose I/O expander. It sits behind a byte interface whose serial framing has already been decoded. A transaction-start pulse marks a new write transfer. The first byte written after that pulse loads the command register. Each later byte is written to, or read from, the register that the command pointer selects.

There are five banks of five 8-bit registers each. Bank 0 is the read-only input bank, which reflects the 40 pin input levels. The other four banks hold the output values, the polarity-inversion settings, the direction configuration and the interrupt mask. Their contents go to neighbouring logic through flat 40-bit buses.

When the auto-increment flag is set, the low three pointer bits step through indices 0 to 4 and wrap, so the pointer stays inside one bank. Each written data byte receives an ACK or NACK verdict one cycle after it arrives. Bytes aimed at the input bank or at undefined codes receive a NACK and change nothing.

Top module: `ioexp_ptr_top`

## Requirements
- R1: After reset the command register holds 0x80. The output and polarity banks hold 0x00. The configuration and mask banks hold 0xFF. `ack_vld_o` and `rd_byte_o` are 0.
- R2: The first `wr_vld_i` byte after an `xfer_start_i` pulse loads the command register and is acknowledged. Command bit 6 is stored as 0, so `cmd_o[6]` is always 0.
- R3: Command bits [5:3] select the bank: 0 input, 1 output, 2 polarity, 3 configuration, 4 mask. Bits [2:0] select byte index 0 to 4 within the bank. Byte k of a bank maps to bits [8k+7:8k] of that bank's 40-bit bus.
- R4: With `cmd_o[7]`=1, every data byte written or read advances `cmd_o[2:0]`. Indices 0 to 3 go to the next value; 4, 5, 6 and 7 go to 0. Bits [7:3] are unchanged.
- R5: With `cmd_o[7]`=0, data bytes leave the command register unchanged, so every byte accesses the same register.
- R6: A data byte written to a defined code in banks 1 to 4 updates that register. `ack_vld_o` is 1 exactly one cycle after each `wr_vld_i` byte, with `ack_o`=1 for accepted bytes.
- R7: A data byte written to bank 0 gets `ack_o`=0 and changes no register.
- R8: A code with bank above 4 or index above 4 is undefined. Writes to it get `ack_o`=0 and change nothing. Reads from it return 0x00.
- R9: One cycle after a `rd_vld_i` pulse with no `wr_vld_i`, `rd_byte_o` holds the selected register. For bank 0 this is the `pin_in_i` byte sampled at that clock edge. `rd_byte_o` holds its value between reads.
- R10: With auto-increment, writing more than five data bytes wraps the index and overwrites the registers written earlier in the same bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| xfer_start_i | input | 1 | Start of a write transfer; the next written byte is a command |
| wr_vld_i | input | 1 | Written byte valid |
| wr_byte_i | input | 8 | Written byte |
| rd_vld_i | input | 1 | Byte read request |
| pin_in_i | input | 40 | Pin input levels (input bank) |
| rd_byte_o | output | 8 | Read data, valid one cycle after request |
| ack_vld_o | output | 1 | Acknowledge verdict valid |
| ack_o | output | 1 | 1 = ACK, 0 = NACK |
| cmd_o | output | 8 | Command register contents |
| out_o | output | 40 | Output bank |
| pol_o | output | 40 | Polarity-inversion bank |
| cfg_o | output | 40 | Configuration bank |
| msk_o | output | 40 | Interrupt mask bank |

## Verification
`cmd_o` exposes the pointer directly. A wrong increment or wrap, or a stray change with auto-increment off, therefore shows on the edge after the offending byte. A wrong bank or index decode shows one cycle after the access: as a wrong `rd_byte_o`, a wrong bit slice changing on a bank bus, or a wrong `ack_o`. The bench compares every output against a behavioural model after every clock, so any divergence is flagged within one cycle of the event that caused it.

// File: rtl/ioexp_pkg.sv
package ioexp_pkg;
  localparam int PTR_W = 3;
  localparam int NUM_BANKS = 5;

  typedef enum logic [PTR_W-1:0] {
    BANK_IN  = 3'd0,
    BANK_OUT = 3'd1,
    BANK_POL = 3'd2,
    BANK_CFG = 3'd3,
    BANK_MSK = 3'd4
  } bank_e;

  function automatic logic [PTR_W-1:0] next_idx(input logic [PTR_W-1:0] idx,
                                               input int num_regs);
    return (int'(idx) >= num_regs - 1) ? '0 : idx + 3'd1;
  endfunction
endpackage

// File: rtl/ioexp_cmd_ptr.sv
module ioexp_cmd_ptr
  import ioexp_pkg::*;
#(
  parameter int NUM_REGS = 5,
  parameter int BYTE_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              xfer_start_i,
  input  logic              wr_vld_i,
  input  logic [BYTE_W-1:0] wr_byte_i,
  input  logic              rd_vld_i,
  output logic [BYTE_W-1:0] cmd_o,
  output logic              data_phase_o
);
  logic [BYTE_W-1:0] cmd_q;
  logic              data_phase_q;
  logic              data_stb;

  assign data_stb = (wr_vld_i && data_phase_q) || (rd_vld_i && !wr_vld_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q        <= 8'h80;
      data_phase_q <= 1'b1;
    end else if (xfer_start_i) begin
      data_phase_q <= 1'b0;
    end else if (wr_vld_i && !data_phase_q) begin
      cmd_q        <= {wr_byte_i[7], 1'b0, wr_byte_i[5:0]};
      data_phase_q <= 1'b1;
    end else if (data_stb && cmd_q[7]) begin
      cmd_q[PTR_W-1:0] <= next_idx(cmd_q[PTR_W-1:0], NUM_REGS);
    end
  end

  assign cmd_o        = cmd_q;
  assign data_phase_o = data_phase_q;
endmodule

// File: rtl/ioexp_bank_regs.sv
module ioexp_bank_regs
  import ioexp_pkg::*;
#(
  parameter int NUM_REGS = 5,
  parameter int BYTE_W   = 8,
  parameter int NUM_WB   = 4,
  parameter logic [NUM_WB*BYTE_W-1:0] RST_VAL = '0,
  localparam int PORT_W = NUM_REGS * BYTE_W
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_en_i,
  input  logic [PTR_W-1:0]              wr_bank_i,
  input  logic [PTR_W-1:0]              wr_idx_i,
  input  logic [BYTE_W-1:0]             wr_data_i,
  output logic [NUM_WB-1:0][PORT_W-1:0] regs_o
);
  for (genvar b = 0; b < NUM_WB; b++) begin : g_bank
    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
      logic [BYTE_W-1:0] reg_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) reg_q <= RST_VAL[b*BYTE_W +: BYTE_W];
        else if (wr_en_i && wr_bank_i == PTR_W'(b + 1) && wr_idx_i == PTR_W'(r))
          reg_q <= wr_data_i;
      end
      assign regs_o[b][r*BYTE_W +: BYTE_W] = reg_q;
    end
  end
endmodule

// File: rtl/ioexp_rd_mux.sv
module ioexp_rd_mux
  import ioexp_pkg::*;
#(
  parameter int NUM_REGS = 5,
  parameter int BYTE_W   = 8,
  parameter int NUM_WB   = 4,
  localparam int PORT_W = NUM_REGS * BYTE_W
) (
  input  logic [PTR_W-1:0]              bank_i,
  input  logic [PTR_W-1:0]              idx_i,
  input  logic [PORT_W-1:0]             pins_i,
  input  logic [NUM_WB-1:0][PORT_W-1:0] regs_i,
  output logic                          defined_o,
  output logic                          writable_o,
  output logic [BYTE_W-1:0]             byte_o
);
  assign defined_o  = (int'(bank_i) <= NUM_WB) && (int'(idx_i) < NUM_REGS);
  assign writable_o = defined_o && (bank_i != BANK_IN);

  always_comb begin
    byte_o = '0;
    if (defined_o) begin
      if (bank_i == BANK_IN) byte_o = pins_i[int'(idx_i)*BYTE_W +: BYTE_W];
      else byte_o = regs_i[int'(bank_i) - 1][int'(idx_i)*BYTE_W +: BYTE_W];
    end
  end
endmodule

// File: rtl/ioexp_ptr_top.sv
module ioexp_ptr_top
  import ioexp_pkg::*;
#(
  parameter int NUM_REGS = 5,
  parameter int BYTE_W   = 8,
  parameter logic [BYTE_W-1:0] CFG_RST = 8'hFF,
  parameter logic [BYTE_W-1:0] MSK_RST = 8'hFF,
  localparam int PORT_W = NUM_REGS * BYTE_W,
  localparam int NUM_WB = NUM_BANKS - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              xfer_start_i,
  input  logic              wr_vld_i,
  input  logic [BYTE_W-1:0] wr_byte_i,
  input  logic              rd_vld_i,
  input  logic [PORT_W-1:0] pin_in_i,
  output logic [BYTE_W-1:0] rd_byte_o,
  output logic              ack_vld_o,
  output logic              ack_o,
  output logic [BYTE_W-1:0] cmd_o,
  output logic [PORT_W-1:0] out_o,
  output logic [PORT_W-1:0] pol_o,
  output logic [PORT_W-1:0] cfg_o,
  output logic [PORT_W-1:0] msk_o
);
  logic                          data_phase;
  logic                          sel_defined, sel_writable;
  logic [BYTE_W-1:0]             sel_byte;
  logic [NUM_WB-1:0][PORT_W-1:0] regs;
  logic                          ack_vld_q, ack_q;
  logic [BYTE_W-1:0]             rd_byte_q;

  ioexp_cmd_ptr #(.NUM_REGS(NUM_REGS), .BYTE_W(BYTE_W)) u_ptr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .xfer_start_i (xfer_start_i),
    .wr_vld_i     (wr_vld_i),
    .wr_byte_i    (wr_byte_i),
    .rd_vld_i     (rd_vld_i),
    .cmd_o        (cmd_o),
    .data_phase_o (data_phase)
  );

  ioexp_rd_mux #(.NUM_REGS(NUM_REGS), .BYTE_W(BYTE_W), .NUM_WB(NUM_WB)) u_mux (
    .bank_i     (cmd_o[5:3]),
    .idx_i      (cmd_o[2:0]),
    .pins_i     (pin_in_i),
    .regs_i     (regs),
    .defined_o  (sel_defined),
    .writable_o (sel_writable),
    .byte_o     (sel_byte)
  );

  // bank 1 at the low byte lane: out, pol, cfg, msk
  ioexp_bank_regs #(
    .NUM_REGS (NUM_REGS),
    .BYTE_W   (BYTE_W),
    .NUM_WB   (NUM_WB),
    .RST_VAL  ({MSK_RST, CFG_RST, {BYTE_W{1'b0}}, {BYTE_W{1'b0}}})
  ) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_vld_i && data_phase && sel_writable && !xfer_start_i),
    .wr_bank_i (cmd_o[5:3]),
    .wr_idx_i  (cmd_o[2:0]),
    .wr_data_i (wr_byte_i),
    .regs_o    (regs)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_vld_q <= 1'b0;
      ack_q     <= 1'b0;
      rd_byte_q <= '0;
    end else begin
      ack_vld_q <= wr_vld_i;
      if (wr_vld_i) ack_q <= data_phase ? sel_writable : 1'b1;
      if (rd_vld_i && !wr_vld_i) rd_byte_q <= sel_byte;
    end
  end

  assign ack_vld_o = ack_vld_q;
  assign ack_o     = ack_q;
  assign rd_byte_o = rd_byte_q;
  assign out_o     = regs[BANK_OUT - 1];
  assign pol_o     = regs[BANK_POL - 1];
  assign cfg_o     = regs[BANK_CFG - 1];
  assign msk_o     = regs[BANK_MSK - 1];
  logic unused_def;
  assign unused_def = sel_defined;
endmodule

// File: rtl/ioexp_ptr_chk.sv
module ioexp_ptr_chk #(
  parameter int PORT_W = 40
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              xfer_start_i,
  input logic              wr_vld_i,
  input logic              rd_vld_i,
  input logic              data_phase,
  input logic [7:0]        cmd_o,
  input logic              ack_vld_o,
  input logic              ack_o,
  input logic [PORT_W-1:0] out_o,
  input logic [PORT_W-1:0] pol_o,
  input logic [PORT_W-1:0] cfg_o,
  input logic [PORT_W-1:0] msk_o
);
  logic data_byte;
  assign data_byte = !xfer_start_i &&
                     ((wr_vld_i && data_phase) || (rd_vld_i && !wr_vld_i));

  // R2
  cmd_bit6_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o[6] == 1'b0);

  // R6
  ack_follows_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_vld_i |=> ack_vld_o);

  // R5
  ai_off_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_byte && !cmd_o[7] |=> $stable(cmd_o));

  // R4
  ai_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_byte && cmd_o[7] && cmd_o[2:0] >= 3'd4 |=> cmd_o[2:0] == 3'd0 && $stable(cmd_o[7:3]));

  // R7
  in_bank_nack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xfer_start_i && wr_vld_i && data_phase && cmd_o[5:3] == 3'd0
    |=> !ack_o && $stable(out_o) && $stable(pol_o) && $stable(cfg_o) && $stable(msk_o));

  // R8
  undef_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xfer_start_i && wr_vld_i && data_phase && (cmd_o[5:3] > 3'd4 || cmd_o[2:0] > 3'd4)
    |=> !ack_o && $stable(out_o) && $stable(pol_o) && $stable(cfg_o) && $stable(msk_o));
endmodule

bind ioexp_ptr_top ioexp_ptr_chk #(.PORT_W(PORT_W)) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .xfer_start_i (xfer_start_i),
  .wr_vld_i     (wr_vld_i),
  .rd_vld_i     (rd_vld_i),
  .data_phase   (data_phase),
  .cmd_o        (cmd_o),
  .ack_vld_o    (ack_vld_o),
  .ack_o        (ack_o),
  .out_o        (out_o),
  .pol_o        (pol_o),
  .cfg_o        (cfg_o),
  .msk_o        (msk_o)
);

// File: tb/ioexp_ptr_top_tb_top.sv
module ioexp_ptr_top_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        xfer_start_i = 1'b0, wr_vld_i = 1'b0, rd_vld_i = 1'b0;
  logic [7:0]  wr_byte_i = '0;
  logic [39:0] pin_in_i = '0;
  logic [7:0]  rd_byte_o, cmd_o;
  logic        ack_vld_o, ack_o;
  logic [39:0] out_o, pol_o, cfg_o, msk_o;

  int errors = 0, checks = 0;
  string tag = "R1";

  logic [7:0] m_cmd;
  logic       m_dp, m_ack_vld, m_ack;
  logic [7:0] m_rd;
  logic [7:0] m_reg [4][5];

  always #10 clk_i = ~clk_i;

  ioexp_ptr_top dut_i (.*);

  task automatic chk(input string t, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", t, act, exp);
    end
  endtask

  task automatic compare_all();
    chk({tag, " cmd"}, 64'(cmd_o), 64'(m_cmd));
    chk({tag, " ack_vld"}, 64'(ack_vld_o), 64'(m_ack_vld));
    if (m_ack_vld) chk({tag, " ack"}, 64'(ack_o), 64'(m_ack));
    chk({tag, " rd_byte"}, 64'(rd_byte_o), 64'(m_rd));
    for (int r = 0; r < 5; r++) begin
      chk({tag, " out"}, 64'(out_o[r*8 +: 8]), 64'(m_reg[0][r]));
      chk({tag, " pol"}, 64'(pol_o[r*8 +: 8]), 64'(m_reg[1][r]));
      chk({tag, " cfg"}, 64'(cfg_o[r*8 +: 8]), 64'(m_reg[2][r]));
      chk({tag, " msk"}, 64'(msk_o[r*8 +: 8]), 64'(m_reg[3][r]));
    end
  endtask

  // one clock: drive, predict, clock, compare
  task automatic cyc(input logic st, input logic wv, input logic [7:0] wb, input logic rv);
    int bk = int'(m_cmd[5:3]);
    int ix = int'(m_cmd[2:0]);
    bit defd = (bk <= 4) && (ix <= 4);
    xfer_start_i = st; wr_vld_i = wv; wr_byte_i = wb; rd_vld_i = rv;
    m_ack_vld = wv;
    if (wv) m_ack = m_dp ? (defd && bk != 0) : 1'b1;
    if (rv && !wv) m_rd = !defd ? 8'h00 : (bk == 0 ? pin_in_i[ix*8 +: 8] : m_reg[bk-1][ix]);
    if (st) m_dp = 1'b0;
    else if (wv && !m_dp) begin
      m_cmd = {wb[7], 1'b0, wb[5:0]};
      m_dp = 1'b1;
    end else if ((wv && m_dp) || (rv && !wv)) begin
      if (wv && defd && bk != 0) m_reg[bk-1][ix] = wb;
      if (m_cmd[7]) m_cmd[2:0] = (ix >= 4) ? 3'd0 : 3'(ix + 1);
    end
    @(posedge clk_i);
    @(negedge clk_i);
    compare_all();
    xfer_start_i = 1'b0; wr_vld_i = 1'b0; rd_vld_i = 1'b0;
  endtask

  task automatic set_cmd(input logic [7:0] c);
    cyc(1'b1, 1'b0, 8'h00, 1'b0);
    cyc(1'b0, 1'b1, c, 1'b0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    m_cmd = 8'h80; m_dp = 1'b1; m_ack_vld = 1'b0; m_ack = 1'b0; m_rd = 8'h00;
    for (int r = 0; r < 5; r++) begin
      m_reg[0][r] = 8'h00; m_reg[1][r] = 8'h00;
      m_reg[2][r] = 8'hFF; m_reg[3][r] = 8'hFF;
    end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    tag = "R1";
    compare_all();
    chk("R1 cmd reset", 64'(cmd_o), 64'h80);

    tag = "R2";
    set_cmd(8'hC9);
    chk("R2 bit6 cleared", 64'(cmd_o), 64'h89);
    chk("R2 cmd ack", 64'(ack_o), 64'h1);

    tag = "R10";
    for (int i = 0; i < 7; i++) cyc(1'b0, 1'b1, 8'(8'h10 + i), 1'b0);
    chk("R10 wrapped overwrite idx1", 64'(out_o[15:8]), 64'h15);
    chk("R4 idx after 7 bytes", 64'(cmd_o[2:0]), 64'd3);

    tag = "R3";
    set_cmd(8'h90);
    for (int i = 0; i < 5; i++) cyc(1'b0, 1'b1, 8'(8'hA0 + i), 1'b0);
    set_cmd(8'h98);
    for (int i = 0; i < 6; i++) cyc(1'b0, 1'b0, 8'h00, 1'b1);
    set_cmd(8'hA1);
    cyc(1'b0, 1'b1, 8'h3C, 1'b0);
    chk("R3 mask byte1 lane", 64'(msk_o[15:8]), 64'h3C);

    tag = "R9";
    pin_in_i = 40'h0123456789;
    set_cmd(8'h80);
    for (int i = 0; i < 5; i++) cyc(1'b0, 1'b0, 8'h00, 1'b1);
    pin_in_i = 40'hFEDCBA9876;
    cyc(1'b0, 1'b0, 8'h00, 1'b1);
    chk("R9 pin byte0 resampled", 64'(rd_byte_o), 64'h76);

    tag = "R5";
    set_cmd(8'h12);
    cyc(1'b0, 1'b1, 8'h5A, 1'b0);
    cyc(1'b0, 1'b1, 8'h6B, 1'b0);
    cyc(1'b0, 1'b0, 8'h00, 1'b1);
    cyc(1'b0, 1'b0, 8'h00, 1'b1);
    chk("R5 same reg", 64'(rd_byte_o), 64'h6B);
    chk("R5 cmd held", 64'(cmd_o), 64'h12);

    tag = "R7";
    set_cmd(8'h81);
    cyc(1'b0, 1'b1, 8'hEE, 1'b0);
    chk("R7 input bank nack", 64'(ack_o), 64'h0);
    cyc(1'b0, 1'b1, 8'hEE, 1'b0);

    tag = "R8";
    set_cmd(8'hA8);
    cyc(1'b0, 1'b1, 8'h77, 1'b0);
    chk("R8 bank5 nack", 64'(ack_o), 64'h0);
    cyc(1'b0, 1'b0, 8'h00, 1'b1);
    chk("R8 undefined read zero", 64'(rd_byte_o), 64'h00);
    set_cmd(8'h8D);
    cyc(1'b0, 1'b1, 8'h99, 1'b0);
    chk("R8 idx5 nack", 64'(ack_o), 64'h0);
    chk("R4 idx5 to 0", 64'(cmd_o[2:0]), 64'd0);
    tag = "R6";
    cyc(1'b0, 1'b1, 8'h42, 1'b0);
    chk("R6 accepted ack", 64'(ack_o), 64'h1);
    chk("R6 out byte0", 64'(out_o[7:0]), 64'h42);
    set_cmd(8'h1F);
    cyc(1'b0, 1'b0, 8'h00, 1'b1);
    chk("R8 idx7 read zero", 64'(rd_byte_o), 64'h00);
    cyc(1'b0, 1'b0, 8'h00, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule